// File: doc/BRIEF.md
# DRAM Open-Page Hit/Miss Sequencer

This block sits between an already-decoded request stream and the command port of a DDR SDRAM controller. The memory has two chip selects with four banks each, so up to eight rows can be open together. The block keeps one row register, with a valid flag, for every chip-select/bank pair.

When a read or write request is accepted, its row is compared against the register chosen by the request's chip select and bank. The outcome sets the command sequence:

- A matching open row (a hit) gets only the read or write command.
- A different open row (a miss) is closed with a precharge, reopened with an activate, and then accessed.
- A pair with no open row gets an activate and then the access.

Programmable wait counts separate precharge from activate, and activate from the access. Each command is held on a ready/valid port until the downstream logic takes it. The column address can be mapped for a 32-bit or a 64-bit data bus. A close-all input lets outside refresh logic mark every row closed.

Top module: `dram_page_seq`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0, and all eight row registers are closed.
- R2: A request whose pair is open with an equal row produces only one command, the access. `cmd_op` is 3 for a read and 4 for a write, and `cmd_addr` holds the mapped column.
- R3: A request whose pair is open with a different row produces three commands in order:
  - precharge (`cmd_op`=1, `cmd_addr`=0),
  - activate (`cmd_op`=2, `cmd_addr`=request row),
  - the access.
  All three carry the request's chip select and bank. After the activate is taken, that pair is open with the new row.
- R4: A request whose pair is closed produces an activate and then the access, with no precharge.
- R5: The row registers are indexed by chip select × 4 + bank. A request changes only its own pair's register.
- R6: After a precharge handshake cycle, the activate becomes valid after exactly `cfg_trp` further cycles. A value of 0 presents it in the very next cycle.
- R7: After an activate handshake cycle, the access becomes valid after exactly `cfg_trcd` further cycles. A value of 0 presents it in the very next cycle.
- R8: `req_word` carries byte-address bits [12:2]. With `cfg_bus32`=1 the column is `req_word[9:0]`, so byte address 0x10 gives column 4. With `cfg_bus32`=0 the column is `req_word[10:1]`, so the same address gives column 2.
- R9: `req_ready` is 1 only while idle. A request offered while busy is ignored. The next request can be taken in the cycle after the access handshake.
- R10: While `cmd_valid` is 1 and `cmd_ready` is 0, the command and all its fields hold steady.
- R11: A cycle with `close_all`=1 closes all eight pairs, so the next access to any pair takes the R4 path.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bus32 | input | 1 | 1 selects 32-bit column mapping, 0 selects 64-bit |
| cfg_trp | input | TW | Wait cycles from precharge to activate |
| cfg_trcd | input | TW | Wait cycles from activate to access |
| close_all | input | 1 | Marks every open row closed |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request taken |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | 1 | Chip select |
| req_bank | input | 2 | Bank |
| req_row | input | ROW_W | Row address |
| req_word | input | COL_W+1 | Byte-address bits from bit 2 upward |
| cmd_valid | output | 1 | Command presented |
| cmd_ready | input | 1 | Command taken downstream |
| cmd_op | output | 3 | 1 precharge, 2 activate, 3 read, 4 write |
| cmd_cs | output | 1 | Command chip select |
| cmd_bank | output | 2 | Command bank |
| cmd_addr | output | ROW_W | Row for activate, column for access, 0 for precharge |

## Verification
The assertions check four things on every cycle:
- stalled commands stay stable (R10);
- an accepted hit goes straight to an access, and an accepted closed-pair request goes straight to an activate (R2, R4);
- a taken activate stores its row, and close-all empties the table (R3, R11);
- the wait counter steps down by one, and the sequencer is single-issue (R9).

Only the bench scenarios can show the following:
- that the full command sequence matches an independent model of eight rows over long random traffic, with rows reused often enough to produce hits (R5);
- that the wait gaps equal the programmed counts, including 0 and the maximum (R6, R7);
- the column mapping in both bus modes (R8);
- that requests offered while busy leave no trace in the command stream (R9).

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [2:0] {
      OP_NOP = 3'd0,
      OP_PRE = 3'd1,
      OP_ACT = 3'd2,
      OP_RD  = 3'd3,
      OP_WR  = 3'd4
   } dram_op_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PRE,
      ST_WAIT_RP,
      ST_ACT,
      ST_WAIT_RCD,
      ST_ACC
   } seq_state_e;

endpackage

// File: rtl/dps_wait_timer.sv
module dps_wait_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [TW-1:0] val_i,
   output logic          last_o
);

   logic [TW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (load_i)
         cnt <= val_i;
      else if (cnt != '0)
         cnt <= cnt - 1'b1;
   end

   assign last_o = (cnt == TW'(1));

   // R6 / R7: a running wait steps down by exactly one per cycle
   a_r6_r7_countdown: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt != '0) |=> (cnt == $past(cnt) - 1'b1));

endmodule

// File: rtl/dps_page_table.sv
module dps_page_table #(
   parameter  int ROW_W   = 14,
   parameter  int ENTRIES = 8,
   localparam int IDX_W   = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_all_i,
   input  logic             wr_en_i,
   input  logic [IDX_W-1:0] wr_idx_i,
   input  logic [ROW_W-1:0] wr_row_i,
   input  logic [IDX_W-1:0] lk_idx_i,
   input  logic [ROW_W-1:0] lk_row_i,
   output logic             lk_open_o,
   output logic             lk_hit_o
);

   logic [ENTRIES-1:0] vld;
   logic [ROW_W-1:0]   rows [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      logic             e_vld;
      logic [ROW_W-1:0] e_row;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            e_vld <= 1'b0;
            e_row <= '0;
         end else if (clr_all_i) begin
            e_vld <= 1'b0;
         end else if (wr_en_i && wr_idx_i == IDX_W'(e)) begin
            e_vld <= 1'b1;
            e_row <= wr_row_i;
         end
      end
      assign vld[e]  = e_vld;
      assign rows[e] = e_row;
   end

   assign lk_open_o = vld[lk_idx_i];
   assign lk_hit_o  = lk_open_o && (rows[lk_idx_i] == lk_row_i);

   // R11: close-all empties the whole table
   a_r11_close_all: assert property (@(posedge clk) disable iff (!rst_n)
      clr_all_i |=> (vld == '0));

   // R3: an activated row is remembered for its own pair
   a_r3_row_stored: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && !clr_all_i) |=>
         (vld[$past(wr_idx_i)] && rows[$past(wr_idx_i)] == $past(wr_row_i)));

endmodule

// File: rtl/dps_col_map.sv
module dps_col_map #(
   parameter int COL_W       = 10,
   parameter bit WIDE_BUS_EN = 1'b1
) (
   input  logic             bus32_i,
   input  logic [COL_W:0]   word_i,
   output logic [COL_W-1:0] col_o
);

   if (WIDE_BUS_EN) begin : g_both
      assign col_o = bus32_i ? word_i[COL_W-1:0] : word_i[COL_W:1];
   end else begin : g_narrow
      assign col_o = word_i[COL_W-1:0];
   end

endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq
   import dps_pkg::*;
#(
   parameter  int ROW_W       = 14,
   parameter  int COL_W       = 10,
   parameter  int CS_N        = 2,
   parameter  int BANKS       = 4,
   parameter  int TW          = 4,
   parameter  bit WIDE_BUS_EN = 1'b1,
   localparam int CS_W        = (CS_N  > 1) ? $clog2(CS_N)  : 1,
   localparam int BK_W        = (BANKS > 1) ? $clog2(BANKS) : 1,
   localparam int ENTRIES     = CS_N * BANKS,
   localparam int IDX_W       = CS_W + BK_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_bus32,
   input  logic [TW-1:0]    cfg_trp,
   input  logic [TW-1:0]    cfg_trcd,
   input  logic             close_all,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic             req_write,
   input  logic [CS_W-1:0]  req_cs,
   input  logic [BK_W-1:0]  req_bank,
   input  logic [ROW_W-1:0] req_row,
   input  logic [COL_W:0]   req_word,
   output logic             cmd_valid,
   input  logic             cmd_ready,
   output logic [2:0]       cmd_op,
   output logic [CS_W-1:0]  cmd_cs,
   output logic [BK_W-1:0]  cmd_bank,
   output logic [ROW_W-1:0] cmd_addr
);

   if (CS_N < 2 || (1 << CS_W) != CS_N) begin : g_chk_cs
      $error("CS_N must be a power of two, at least 2");
   end
   if (BANKS < 2 || (1 << BK_W) != BANKS) begin : g_chk_bk
      $error("BANKS must be a power of two, at least 2");
   end
   if (ROW_W <= COL_W) begin : g_chk_w
      $error("ROW_W must exceed COL_W");
   end
   if (TW < 1) begin : g_chk_tw
      $error("TW must be at least 1");
   end

   seq_state_e       state, state_nx;
   logic             q_wr;
   logic [CS_W-1:0]  q_cs;
   logic [BK_W-1:0]  q_bank;
   logic [ROW_W-1:0] q_row;
   logic [COL_W-1:0] q_col;
   logic [COL_W-1:0] col_in;
   logic             accept, cmd_hs;
   logic             lk_open, lk_hit;
   logic             tm_load, tm_last;
   logic [TW-1:0]    tm_val;
   dram_op_e         op;

   assign accept    = req_valid && req_ready;
   assign cmd_hs    = cmd_valid && cmd_ready;
   assign req_ready = (state == ST_IDLE);

   dps_col_map #(.COL_W(COL_W), .WIDE_BUS_EN(WIDE_BUS_EN)) u_col (
      .bus32_i (cfg_bus32),
      .word_i  (req_word),
      .col_o   (col_in)
   );

   dps_page_table #(.ROW_W(ROW_W), .ENTRIES(ENTRIES)) u_pages (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_all_i (close_all),
      .wr_en_i   (cmd_hs && state == ST_ACT),
      .wr_idx_i  ({q_cs, q_bank}),
      .wr_row_i  (q_row),
      .lk_idx_i  ({req_cs, req_bank}),
      .lk_row_i  (req_row),
      .lk_open_o (lk_open),
      .lk_hit_o  (lk_hit)
   );

   assign tm_load = cmd_hs && (state == ST_PRE || state == ST_ACT);
   assign tm_val  = (state == ST_PRE) ? cfg_trp : cfg_trcd;

   dps_wait_timer #(.TW(TW)) u_wait (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (tm_load),
      .val_i  (tm_val),
      .last_o (tm_last)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE:     if (accept) state_nx = lk_hit  ? ST_ACC :
                                             lk_open ? ST_PRE : ST_ACT;
         ST_PRE:      if (cmd_hs) state_nx = (cfg_trp == '0)  ? ST_ACT : ST_WAIT_RP;
         ST_WAIT_RP:  if (tm_last) state_nx = ST_ACT;
         ST_ACT:      if (cmd_hs) state_nx = (cfg_trcd == '0) ? ST_ACC : ST_WAIT_RCD;
         ST_WAIT_RCD: if (tm_last) state_nx = ST_ACC;
         ST_ACC:      if (cmd_hs) state_nx = ST_IDLE;
         default:     state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         q_wr   <= 1'b0;
         q_cs   <= '0;
         q_bank <= '0;
         q_row  <= '0;
         q_col  <= '0;
      end else begin
         state <= state_nx;
         if (accept) begin
            q_wr   <= req_write;
            q_cs   <= req_cs;
            q_bank <= req_bank;
            q_row  <= req_row;
            q_col  <= col_in;
         end
      end
   end

   always_comb begin
      unique case (state)
         ST_PRE:  op = OP_PRE;
         ST_ACT:  op = OP_ACT;
         ST_ACC:  op = q_wr ? OP_WR : OP_RD;
         default: op = OP_NOP;
      endcase
   end

   assign cmd_valid = (op != OP_NOP);
   assign cmd_op    = op;
   assign cmd_cs    = q_cs;
   assign cmd_bank  = q_bank;
   assign cmd_addr  = (state == ST_ACT) ? q_row :
                      (state == ST_ACC) ? {{(ROW_W-COL_W){1'b0}}, q_col} : '0;

   // R10: a stalled command stays put
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_cs)
                                     && $stable(cmd_bank) && $stable(cmd_addr)));

   // R2: an accepted hit goes straight to the access
   a_r2_hit_direct: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && lk_hit) |=> (cmd_valid && (cmd_op == OP_RD || cmd_op == OP_WR)));

   // R4: an accepted request to a closed pair starts with activate
   a_r4_closed_act: assert property (@(posedge clk) disable iff (!rst_n)
      (accept && !lk_open) |=> (cmd_valid && cmd_op == OP_ACT));

   // R9: single issue; idle again right after the access is taken
   a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready);
   a_r9_idle_after_access: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_hs && (cmd_op == OP_RD || cmd_op == OP_WR)) |=> req_ready);

endmodule

// File: tb/tb_dram_page_seq.sv
module tb_dram_page_seq;
   localparam int ROW_W = 14;
   localparam int COL_W = 10;
   localparam int TW    = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_bus32 = 1'b1;
   logic [TW-1:0]    cfg_trp = '0, cfg_trcd = '0;
   logic             close_all = 1'b0;
   logic             req_valid = 1'b0, req_write = 1'b0;
   logic             req_ready;
   logic [0:0]       req_cs = '0;
   logic [1:0]       req_bank = '0;
   logic [ROW_W-1:0] req_row = '0;
   logic [COL_W:0]   req_word = '0;
   logic             cmd_valid, cmd_ready = 1'b0;
   logic [2:0]       cmd_op;
   logic [0:0]       cmd_cs;
   logic [1:0]       cmd_bank;
   logic [ROW_W-1:0] cmd_addr;

   always #10 clk = ~clk;

   dram_page_seq #(.ROW_W(ROW_W), .COL_W(COL_W), .TW(TW)) dut (
      .clk(clk), .rst_n(rst_n), .cfg_bus32(cfg_bus32), .cfg_trp(cfg_trp),
      .cfg_trcd(cfg_trcd), .close_all(close_all), .req_valid(req_valid),
      .req_ready(req_ready), .req_write(req_write), .req_cs(req_cs),
      .req_bank(req_bank), .req_row(req_row), .req_word(req_word),
      .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
      .cmd_cs(cmd_cs), .cmd_bank(cmd_bank), .cmd_addr(cmd_addr)
   );

   int n_chk = 0, n_err = 0;
   bit finished = 1'b0;
   bit m_open [8];
   int m_row  [8];

   task automatic chk_eq(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
      end
   endtask

   function automatic int map_col(int word, bit b32);
      return b32 ? (word & 1023) : ((word >> 1) & 1023);
   endfunction

   task automatic run_req(bit wr, int cs, int bk, int row, int word, int trp,
                          int trcd, bit b32, int max_stall, string note);
      int idx = cs * 4 + bk;
      int ops[3], gaps[3], adr[3], gtag[3];
      int n, loc, w;
      string cls;
      int acc = wr ? 4 : 3;
      int col = map_col(word, b32);
      if (m_open[idx] && m_row[idx] == row) begin
         cls = "R2"; n = 1;
         ops[0] = acc; gaps[0] = 1; adr[0] = col; gtag[0] = 2;
      end else if (m_open[idx]) begin
         cls = "R3"; n = 3;
         ops[0] = 1;   gaps[0] = 1;        adr[0] = 0;   gtag[0] = 3;
         ops[1] = 2;   gaps[1] = trp + 1;  adr[1] = row; gtag[1] = 6;
         ops[2] = acc; gaps[2] = trcd + 1; adr[2] = col; gtag[2] = 7;
      end else begin
         cls = "R4"; n = 2;
         ops[0] = 2;   gaps[0] = 1;        adr[0] = row; gtag[0] = 4;
         ops[1] = acc; gaps[1] = trcd + 1; adr[1] = col; gtag[1] = 7;
      end
      @(negedge clk);
      cfg_bus32 = b32; cfg_trp = TW'(trp); cfg_trcd = TW'(trcd);
      req_write = wr; req_cs = 1'(cs); req_bank = 2'(bk);
      req_row = ROW_W'(row); req_word = (COL_W+1)'(word); req_valid = 1'b1;
      chk_eq("R9", "req_ready when idle", int'(req_ready), 1);
      @(negedge clk);
      loc = 1;
      // junk request held while busy: must be ignored (R9)
      req_cs = ~req_cs; req_bank = ~req_bank; req_row = ~req_row; req_write = ~req_write;
      chk_eq("R9", "req_ready when busy", int'(req_ready), 0);
      for (int k = 0; k < n; k++) begin
         string t = {cls, " ", note};
         w = 0;
         while (!cmd_valid && w < 100) begin
            @(negedge clk); loc++; w++;
         end
         chk_eq(gtag[k] == 6 ? "R6" : gtag[k] == 7 ? "R7" : t, "gap", loc, gaps[k]);
         chk_eq(t, "cmd_op", int'(cmd_op), ops[k]);
         chk_eq(t, "cmd_cs", int'(cmd_cs), cs);
         chk_eq(t, "cmd_bank", int'(cmd_bank), bk);
         chk_eq(ops[k] >= 3 ? {"R8 ", t} : t, "cmd_addr", int'(cmd_addr), adr[k]);
         for (int s = $urandom_range(0, max_stall); s > 0; s--) begin
            @(negedge clk);
            chk_eq("R10", "stalled op", cmd_valid ? int'(cmd_op) : -1, ops[k]);
            chk_eq("R10", "stalled addr", int'(cmd_addr), adr[k]);
         end
         cmd_ready = 1'b1;
         @(negedge clk);
         cmd_ready = 1'b0;
         loc = 1;
      end
      req_valid = 1'b0;
      chk_eq("R9", "req_ready after access", int'(req_ready), 1);
      m_open[idx] = 1'b1;
      m_row[idx]  = row;
   endtask

   task automatic pulse_close;
      @(negedge clk); close_all = 1'b1;
      @(negedge clk); close_all = 1'b0;
      for (int i = 0; i < 8; i++) m_open[i] = 1'b0;
   endtask

   initial begin
      void'($urandom(32'h5eed_1234));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk_eq("R1", "req_ready after reset", int'(req_ready), 1);
      chk_eq("R1", "cmd_valid after reset", int'(cmd_valid), 0);
      // first touches: closed pairs (R1, R4); byte 0x10 -> column 4 (R8)
      run_req(0, 0, 0, 5, 'h4, 2, 3, 1, 0, "R1");
      run_req(1, 0, 0, 5, 'h4, 2, 3, 1, 1, "R8 32-bit");
      run_req(0, 0, 0, 5, 'h4, 2, 3, 0, 1, "R8 64-bit");
      // other pair opens without disturbing pair 0 (R5)
      run_req(0, 1, 3, 9, 'h3ff, 1, 1, 1, 0, "R5");
      run_req(1, 0, 0, 5, 'h7ff, 1, 1, 0, 0, "R5");
      run_req(0, 1, 3, 9, 'h155, 1, 1, 1, 0, "R5");
      // miss with zero waits, then maximum waits (R6, R7)
      run_req(0, 0, 0, 7, 'h22, 0, 0, 1, 2, "R6 R7 zero");
      run_req(1, 0, 0, 8, 'h23, 15, 15, 1, 2, "R6 R7 max");
      // close-all: both pairs back to activate-first (R11)
      pulse_close();
      run_req(0, 0, 0, 8, 'h10, 1, 2, 1, 0, "R11");
      run_req(0, 1, 3, 9, 'h10, 1, 2, 1, 0, "R11");
      // constrained random traffic over a small row set
      for (int i = 0; i < 400; i++) begin
         if ($urandom_range(0, 60) == 0) pulse_close();
         run_req(1'($urandom), $urandom_range(0, 1), $urandom_range(0, 3),
                 $urandom_range(0, 3), $urandom_range(0, 2047),
                 $urandom_range(0, 4), $urandom_range(0, 4),
                 ($urandom_range(0, 3) != 0), 3, "R5 rand");
      end
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog expired actual=1 expected=0");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end
endmodule